// File: doc/BRIEF.md
# Two-Wire Register Slave with Autoincrementing Pointer

This block lets a host on a two-wire serial bus read and write a bank of 17 byte-wide control registers at indices 0x00 to 0x10. The slave watches the bus with the system clock. It synchronizes SCL and SDA, then finds clock edges and START/STOP conditions from the synchronized levels. It answers only to a 7-bit device address whose upper four bits are fixed and whose lower three bits come from strap pins. Three bits let up to eight of these slaves share one bus.

In a write transfer, the first byte after the address loads a register pointer. Each data byte after it is committed to the register file while the slave acknowledges it, and the pointer then steps forward by one. The pointer stops at the top register and does not wrap. A read transfer starts at the current pointer. A repeated START lets the host set the pointer and then turn the bus around for reading, without releasing the bus in between. The register storage sits outside this block and is reached through a simple write strobe and an asynchronous read port.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose bits 7..1 equal 1,0,0,0,addr_sel_i[2],addr_sel_i[1],addr_sel_i[0]. Bit 0 of that byte selects the direction: 1 is read, 0 is write. It acknowledges by asserting sda_oe_o, which pulls SDA low, for the whole 9th clock. For any other address it never asserts sda_oe_o or reg_we_o until the next START.
- R2: An SDA fall while SCL is high is a START. It restarts address reception from any state, so a repeated START without STOP is accepted with either direction. An SDA rise while SCL is high is a STOP. A STOP ends the transfer and leaves SDA released.
- R3: Every byte travels MSB first. sda_oe_o changes only while SCL is low.
- R4: In a write transfer, the first byte after the address is the pointer. A value of 0x10 or less is acknowledged and becomes reg_addr_o.
- R5: A pointer byte above 0x10 is not acknowledged. The pointer keeps its old value, and later bytes cause no write and no acknowledge until the next START.
- R6: Each data byte of a write transfer is acknowledged. During that acknowledge it produces a single-cycle reg_we_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte.
- R7: After each written byte, the pointer increments by one and saturates at 0x10, so surplus bytes overwrite register 0x10.
- R8: In a read transfer, the slave sends the register at the pointer and releases SDA for the host's acknowledge bit. The pointer advances after every byte it sends, saturating at 0x10. The pointer is kept across STOP, so a later read starts at the pointer the last transfer left.
- R9: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R10: After reset, sda_oe_o and reg_we_o are 0 and reg_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level read from the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 3 | Low three bits of the device address |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_addr_o | output | 5 | Register pointer, index for both read and write |
| reg_wdata_o | output | 8 | Byte to write |
| reg_rdata_i | input | 8 | Content of the register at reg_addr_o |

## Verification
The hardest state to reach is one where the pointer has been pushed into saturation by a long burst, and the bus is then turned around by a repeated START or resumed after a STOP. Only the bytes read back show where the pointer ended up. The bench reaches it with directed bursts that cross 0x10 and with random transfers whose start index and length are drawn so that many of them run past the top register. Each random write is followed by a read of the same span. Foreign addresses and out-of-range pointer bytes follow each other directly, so any write that escapes them shows up in the write-strobe count.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TX_ACK
  } state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1000;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edge with clock held high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_slv_ptr.sv
module i2c_slv_ptr #(
  parameter int REG_COUNT = 17,
  localparam int AW = $clog2(REG_COUNT),
  localparam logic [AW-1:0] TOP = AW'(REG_COUNT - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ptr_o <= '0;
    else if (load_i)               ptr_o <= load_val_i;
    else if (inc_i && ptr_o != TOP) ptr_o <= ptr_o + AW'(1);
  end
endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
#(
  parameter int REG_COUNT = 17,
  localparam int AW = $clog2(REG_COUNT),
  localparam logic [7:0] TOP_B = 8'(REG_COUNT - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [6:0]    dev_addr_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          ptr_load_o,
  output logic [AW-1:0] ptr_val_o,
  output logic          ptr_inc_o
);
  state_e     state_q;
  phase_e     phase_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shift_q;
  logic       rw_q;
  logic       byte_done, quiet;

  assign quiet     = ~start_i & ~stop_i;
  assign byte_done = quiet & (state_q == ST_RX) & scl_fall_i & (bit_cnt_q == 4'd8);

  assign ptr_load_o = byte_done & (phase_q == PH_PTR) & (shift_q <= TOP_B);
  assign ptr_val_o  = shift_q[AW-1:0];
  assign ptr_inc_o  = quiet & scl_fall_i &
                      (((state_q == ST_ACK) & (phase_q == PH_DATA)) |
                       ((state_q == ST_TX) & (bit_cnt_q == 4'd7)));
  assign wdata_o    = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      rw_q      <= 1'b0;
      sda_oe_o  <= 1'b0;
      we_o      <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              shift_q   <= {shift_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              bit_cnt_q <= '0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (shift_q[7:1] == dev_addr_i) begin
                    rw_q     <= shift_q[0];
                    state_q  <= ST_ACK;
                    sda_oe_o <= 1'b1;
                  end else state_q <= ST_IDLE;
                end
                PH_PTR: begin
                  if (shift_q <= TOP_B) begin
                    state_q  <= ST_ACK;
                    sda_oe_o <= 1'b1;
                  end else state_q <= ST_IDLE;
                end
                default: begin
                  state_q  <= ST_ACK;
                  sda_oe_o <= 1'b1;
                  we_o     <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (phase_q == PH_ADDR && rw_q) begin
                state_q  <= ST_TX;
                shift_q  <= rdata_i;
                sda_oe_o <= ~rdata_i[7];
              end else begin
                state_q  <= ST_RX;
                sda_oe_o <= 1'b0;
                phase_q  <= (phase_q == PH_ADDR) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd7) begin
                state_q   <= ST_TX_ACK;
                sda_oe_o  <= 1'b0;
                bit_cnt_q <= '0;
              end else begin
                shift_q   <= {shift_q[6:0], 1'b0};
                sda_oe_o  <= ~shift_q[6];
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i && sda_s_i) begin
              state_q <= ST_IDLE;   // host declined more data
            end else if (scl_fall_i) begin
              state_q  <= ST_TX;
              shift_q  <= rdata_i;
              sda_oe_o <= ~rdata_i[7];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int REG_COUNT   = 17,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    addr_sel_i,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  input  logic [7:0]    reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slv_ctrl #(.REG_COUNT(REG_COUNT)) ctrl_i (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .dev_addr_i({DEV_PREFIX, addr_sel_i}),
    .rdata_i(reg_rdata_i),
    .sda_oe_o, .we_o(reg_we_o), .wdata_o(reg_wdata_o),
    .ptr_load_o(ptr_load), .ptr_val_o(ptr_val), .ptr_inc_o(ptr_inc)
  );

  i2c_slv_ptr #(.REG_COUNT(REG_COUNT)) ptr_i (
    .clk_i, .rst_ni,
    .load_i(ptr_load), .load_val_i(ptr_val), .inc_i(ptr_inc),
    .ptr_o(reg_addr_o)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int REG_COUNT = 17,
  localparam int AW = $clog2(REG_COUNT),
  localparam logic [AW-1:0] TOP = AW'(REG_COUNT - 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o
);
  p_we_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_in_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> sda_oe_o);

  p_ptr_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_o <= TOP);

  p_sda_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.REG_COUNT(REG_COUNT)) chk_i (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .reg_we_o, .reg_addr_o
);

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] addr_sel = 3'b101;
  logic sda_oe, reg_we;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] rf [NREG];
  logic [7:0] exp_rf [NREG];
  int checks = 0, errors = 0, we_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .reg_we_o(reg_we),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
    end else if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign reg_rdata = (reg_addr < NREG) ? rf[reg_addr] : 8'h00;

  function automatic int sat_inc(int p);
    return (p >= NREG - 1) ? NREG - 1 : p + 1;
  endfunction

  function automatic logic [7:0] dev_byte(logic [2:0] sel, logic rd);
    return {4'b1000, sel, rd};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    if (!scl_m) begin
      clk_n(4); sda_m = 1'b1; clk_n(4); scl_m = 1'b1;
    end
    clk_n(8); sda_m = 1'b0; clk_n(8); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    clk_n(4); sda_m = 1'b0; clk_n(4); scl_m = 1'b1;
    clk_n(8); sda_m = 1'b1; clk_n(8);
  endtask

  task automatic put_bit(input logic b, output logic seen);
    clk_n(4); sda_m = b; clk_n(4); scl_m = 1'b1;
    clk_n(4); seen = sda_line; clk_n(4); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      b[i] = s;
    end
    put_bit(~mack, s);
  endtask

  // write n bytes from pointer p, updating the expected image
  task automatic write_seq(input int p, input int n, input logic [7:0] d [4]);
    logic a;
    int q;
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a); chk("R1 addr ack", a, 1);
    send_byte(8'(p), a);                    chk("R4 ptr ack", a, 1);
    q = p;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);                   chk("R6 data ack", a, 1);
      exp_rf[q] = d[i];
      q = sat_inc(q);
    end
    bus_stop();
  endtask

  // set pointer, repeated START, read n bytes, NACK the last
  task automatic read_seq(input int p, input int n);
    logic a;
    logic [7:0] b;
    int q;
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a); chk("R1 addr ack", a, 1);
    send_byte(8'(p), a);                    chk("R4 ptr ack", a, 1);
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b1), a); chk("R2 rstart ack", a, 1);
    q = p;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk("R8 read data", b, exp_rf[q]);
      q = sat_inc(q);
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    logic [7:0] d [4];
    int w0;
    void'($urandom(32'd7));
    for (int i = 0; i < NREG; i++) exp_rf[i] = 8'h00;
    clk_n(5);
    rst_ni = 1'b1;
    clk_n(3);
    // R10 reset state
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 we", reg_we, 0);
    chk("R10 addr", reg_addr, 0);

    // single write, R6 strobe count
    w0 = we_cnt;
    d = '{8'hA5, 8'h00, 8'h00, 8'h00};
    write_seq(3, 1, d);
    chk("R6 one strobe", we_cnt - w0, 1);
    chk("R4 ptr after write", reg_addr, 4);
    chk("R6 reg content", rf[3], 8'hA5);

    // MSB-first order, R3
    d = '{8'h01, 8'h80, 8'h00, 8'h00};
    write_seq(1, 2, d);
    read_seq(1, 2);
    chk("R3 bit order", rf[2], 8'h80);

    // burst crossing the top, R7
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    write_seq(14, 4, d);
    chk("R7 saturated ptr", reg_addr, 16);
    chk("R7 top overwritten", rf[16], 8'h44);
    chk("R7 0x0F kept", rf[15], 8'h22);
    read_seq(14, 4);
    read_seq(16, 3);

    // host NACK then more clocks, R9
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a);
    send_byte(8'd3, a);
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b1), a);
    recv_byte(1'b0, b);
    chk("R9 byte before nack", b, exp_rf[3]);
    recv_byte(1'b1, b);
    chk("R9 bus released", b, 8'hFF);
    chk("R9 sda_oe low", sda_oe, 0);
    bus_stop();

    // pointer kept across STOP, R8
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a);
    send_byte(8'd5, a);
    bus_stop();
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b1), a); chk("R8 read addr ack", a, 1);
    recv_byte(1'b0, b);
    chk("R8 start at kept ptr", b, exp_rf[5]);
    bus_stop();

    // foreign address, R1
    w0 = we_cnt;
    bus_start();
    send_byte(dev_byte(addr_sel ^ 3'b010, 1'b0), a); chk("R1 foreign nack", a, 0);
    send_byte(8'd2, a);                               chk("R1 no ptr ack", a, 0);
    send_byte(8'h5A, a);                              chk("R1 no data ack", a, 0);
    bus_stop();
    chk("R1 no write", we_cnt - w0, 0);

    // pointer out of range, R5
    bus_start();
    send_byte(dev_byte(addr_sel, 1'b0), a);
    send_byte(8'h11, a);   chk("R5 ptr nack", a, 0);
    send_byte(8'h77, a);   chk("R5 data ignored", a, 0);
    bus_stop();
    chk("R5 no write", we_cnt - w0, 0);
    chk("R5 ptr unchanged", reg_addr, 6);

    // other strap value, then random traffic
    addr_sel = 3'b010;
    for (int t = 0; t < 24; t++) begin
      int p, n;
      p = $urandom_range(0, NREG - 1);
      n = $urandom_range(1, 4);
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      write_seq(p, n, d);
      read_seq(p, n);
    end
    for (int i = 0; i < NREG; i++) chk("R7 final image", rf[i], exp_rf[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule